// File: doc/BRIEF.md
# TLB Maintenance Register File

This block is the register window through which software maintains a 64-entry translation buffer. It keeps an index register, a process-ID register and a zone-protection word, together with the per-entry tag words, 64-bit data words and owner IDs. A simple register bus (valid, write, register number, extended flag, write data) reads and writes these registers; a read answers one cycle later on a registered read port.

Two registers act as windows onto the entry selected by the index register: one for the data word, one for the tag word. Touching the tag window also moves the owner ID between the entry and the process-ID register. Writing the search register hands the page number to an external lookup engine over a request/acknowledge port; when the engine answers, the index register receives either the matching entry number or its miss flag. Changes of the process ID or of the zone word raise a one-cycle flush pulse for the translation caches downstream.

Top module: `tlb_mgmt_regs`

## Requirements
- R1: After reset every register, every entry and the flush output are zero, so reads of the index, process-ID, zone, tag and data registers return zero.
- R2: Register numbers are 0 data window, 1 tag window, 2 zone word, 3 process ID, 4 index, 5 search; the windows access the entry picked by the index register's low bits (bits [5:0] for 64 entries), and read data appears one cycle after the request.
- R3: A tag-window write stores the current process-ID byte as the entry's owner ID; a tag-window read loads that owner ID into the process-ID register.
- R4: An index write changes bits [30:0] only; bit 31 is the miss flag and software cannot write it.
- R5: A search write sends the written value with its low 10 bits cleared, plus the user-mode input, to the lookup engine; a hit loads the index register with the entry number (miss flag cleared), a miss sets bit 31 and keeps bits [30:0].
- R6: Reading the search register returns zero.
- R7: Writes to the process-ID, zone and search registers take effect only when the access level input is 2 or 3.
- R8: Reads of the data window, tag window, process-ID and zone registers need bit 0 of the access level; the index register reads without it.
- R9: When the MMU level input is below 2 or the access level is 0, every access is ignored and reads return zero; register numbers 6 and 7 are ignored too.
- R10: The extended flag selects bits [63:32] of the data word on the data window; with any other register the whole access is ignored and reads return zero.
- R11: The flush output pulses for one cycle after a process-ID or zone write whose value differs from the stored one, and stays low for an equal value.
- R12: While a search is outstanding the busy output is high, the request stays asserted until acknowledged, and bus accesses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_level | input | 2 | MMU level; below 2 closes the window |
| cfg_access | input | 2 | Access level for maintenance registers |
| user_mode | input | 1 | Current privilege, forwarded with a search |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 write, 0 read |
| req_ext | input | 1 | Upper-half select for the data window |
| req_reg | input | 3 | Register number |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | 32 | Read response data |
| busy | output | 1 | Search outstanding |
| flush | output | 1 | Translation cache flush pulse |
| lk_req | output | 1 | Lookup request to the engine |
| lk_vpn | output | 32 | Page-aligned search address |
| lk_user | output | 1 | Privilege of the search |
| lk_ack | input | 1 | Lookup answer strobe |
| lk_hit | input | 1 | Lookup found an entry |
| lk_index | input | 6 | Matching entry number |

## Verification
The hardest state to reach is the miss flag interacting with later index writes: bit 31 can only be set by a missed search, so the bench first drives a search whose engine answer is a miss, then writes the index with bit 31 clear and confirms the flag survives, and finally lets a hit clear it. Accesses issued while the engine is still thinking are reached by holding the acknowledge back several cycles and writing the index in that gap. The owner-ID transfer needs a sequence of process-ID write, tag write, process-ID change and tag read before the process-ID register shows the effect.

// File: rtl/tlb_mgmt_pkg.sv
package tlb_mgmt_pkg;

    typedef enum logic [2:0] {
        REG_DATA   = 3'd0,
        REG_TAG    = 3'd1,
        REG_ZONE   = 3'd2,
        REG_PROC   = 3'd3,
        REG_INDEX  = 3'd4,
        REG_SEARCH = 3'd5
    } reg_e;

    typedef enum logic [2:0] {
        RSEL_ZERO,
        RSEL_DATA,
        RSEL_TAG,
        RSEL_ZONE,
        RSEL_PROC,
        RSEL_INDEX
    } rsel_e;

    typedef struct packed {
        logic  wr_data;
        logic  wr_tag;
        logic  wr_zone;
        logic  wr_proc;
        logic  wr_index;
        logic  start_search;
        logic  tag_read;
        logic  rd_en;
        rsel_e rsel;
    } act_t;

    function automatic logic [31:0] page_mask(input int unsigned bits);
        page_mask = ~((32'h1 << bits) - 32'h1);
    endfunction

endpackage

// File: rtl/tlb_mgmt_decode.sv
module tlb_mgmt_decode
    import tlb_mgmt_pkg::*;
(
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       req_ext,
    input  logic [2:0] req_reg,
    input  logic [1:0] cfg_level,
    input  logic [1:0] cfg_access,
    input  logic       busy,
    output act_t       act
);
    logic open_win;
    logic ext_bad;
    logic gate;

    always_comb begin
        open_win = (cfg_level >= 2'd2) && (cfg_access != 2'd0);
        ext_bad  = req_ext && (req_reg != REG_DATA);
        gate     = req_valid && !busy && open_win && !ext_bad;

        act      = '0;
        act.rsel = RSEL_ZERO;
        act.rd_en = req_valid && !req_write;

        if (gate && req_write) begin
            case (req_reg)
                REG_DATA:   act.wr_data      = 1'b1;
                REG_TAG:    act.wr_tag       = 1'b1;
                REG_INDEX:  act.wr_index     = 1'b1;
                REG_ZONE:   act.wr_zone      = cfg_access[1];
                REG_PROC:   act.wr_proc      = cfg_access[1];
                REG_SEARCH: act.start_search = cfg_access[1];
                default:    ;
            endcase
        end else if (gate) begin
            case (req_reg)
                REG_DATA: if (cfg_access[0]) act.rsel = RSEL_DATA;
                REG_TAG: if (cfg_access[0]) begin
                    act.rsel     = RSEL_TAG;
                    act.tag_read = 1'b1;
                end
                REG_ZONE:  if (cfg_access[0]) act.rsel = RSEL_ZONE;
                REG_PROC:  if (cfg_access[0]) act.rsel = RSEL_PROC;
                REG_INDEX: act.rsel = RSEL_INDEX;
                default:   act.rsel = RSEL_ZERO;
            endcase
        end
    end
endmodule

// File: rtl/tlb_mgmt_store.sv
module tlb_mgmt_store #(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned PROC_W  = 8,
    localparam int unsigned SEL_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  sel,
    input  logic              wr_data,
    input  logic              wr_upper,
    input  logic              wr_tag,
    input  logic [31:0]       wdata,
    input  logic [PROC_W-1:0] proc_id,
    output logic [31:0]       tag_out,
    output logic [63:0]       data_out,
    output logic [PROC_W-1:0] owner_out
);
    logic [31:0]       tag_mem   [ENTRIES];
    logic [63:0]       data_mem  [ENTRIES];
    logic [PROC_W-1:0] owner_mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(ENTRIES); i++) begin
                tag_mem[i]   <= '0;
                data_mem[i]  <= '0;
                owner_mem[i] <= '0;
            end
        end else begin
            if (wr_tag) begin
                tag_mem[sel]   <= wdata;
                owner_mem[sel] <= proc_id;
            end
            if (wr_data) begin
                if (wr_upper) data_mem[sel][63:32] <= wdata;
                else          data_mem[sel][31:0]  <= wdata;
            end
        end
    end

    assign tag_out   = tag_mem[sel];
    assign data_out  = data_mem[sel];
    assign owner_out = owner_mem[sel];
endmodule

// File: rtl/tlb_mgmt_search.sv
module tlb_mgmt_search
    import tlb_mgmt_pkg::*;
#(
    parameter int unsigned PAGE_BITS = 10,
    parameter int unsigned SEL_W     = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [31:0]      wdata,
    input  logic             user_mode,
    output logic             lk_req,
    output logic [31:0]      lk_vpn,
    output logic             lk_user,
    input  logic             lk_ack,
    input  logic             lk_hit,
    input  logic [SEL_W-1:0] lk_index,
    output logic             busy,
    output logic             res_valid,
    output logic             res_hit,
    output logic [SEL_W-1:0] res_index
);
    localparam logic [31:0] MASK = page_mask(PAGE_BITS);

    typedef enum logic {S_IDLE, S_WAIT} state_e;
    state_e state_q;
    logic [31:0] vpn_q;
    logic        user_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            vpn_q   <= '0;
            user_q  <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: if (start) begin
                    state_q <= S_WAIT;
                    vpn_q   <= wdata & MASK;
                    user_q  <= user_mode;
                end
                S_WAIT: if (lk_ack) state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy      = (state_q == S_WAIT);
    assign lk_req    = busy;
    assign lk_vpn    = vpn_q;
    assign lk_user   = user_q;
    assign res_valid = busy && lk_ack;
    assign res_hit   = lk_hit;
    assign res_index = lk_index;
endmodule

// File: rtl/tlb_mgmt_regs.sv
module tlb_mgmt_regs
    import tlb_mgmt_pkg::*;
#(
    parameter int unsigned ENTRIES   = 64,
    parameter int unsigned PROC_W    = 8,
    parameter int unsigned PAGE_BITS = 10,
    localparam int unsigned SEL_W    = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cfg_level,
    input  logic [1:0]       cfg_access,
    input  logic             user_mode,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_ext,
    input  logic [2:0]       req_reg,
    input  logic [31:0]      req_wdata,
    output logic             rd_valid,
    output logic [31:0]      rd_data,
    output logic             busy,
    output logic             flush,
    output logic             lk_req,
    output logic [31:0]      lk_vpn,
    output logic             lk_user,
    input  logic             lk_ack,
    input  logic             lk_hit,
    input  logic [SEL_W-1:0] lk_index
);
    act_t              act;
    logic [31:0]       index_q;
    logic [PROC_W-1:0] proc_q;
    logic [31:0]       zone_q;
    logic [31:0]       rd_data_q;
    logic              rd_valid_q;
    logic              flush_q;

    logic [31:0]       tag_out;
    logic [63:0]       data_out;
    logic [PROC_W-1:0] owner_out;
    logic              res_valid;
    logic              res_hit;
    logic [SEL_W-1:0]  res_index;
    logic [31:0]       rd_next;

    tlb_mgmt_decode u_decode (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_ext    (req_ext),
        .req_reg    (req_reg),
        .cfg_level  (cfg_level),
        .cfg_access (cfg_access),
        .busy       (busy),
        .act        (act)
    );

    tlb_mgmt_store #(.ENTRIES(ENTRIES), .PROC_W(PROC_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .sel       (index_q[SEL_W-1:0]),
        .wr_data   (act.wr_data),
        .wr_upper  (req_ext),
        .wr_tag    (act.wr_tag),
        .wdata     (req_wdata),
        .proc_id   (proc_q),
        .tag_out   (tag_out),
        .data_out  (data_out),
        .owner_out (owner_out)
    );

    tlb_mgmt_search #(.PAGE_BITS(PAGE_BITS), .SEL_W(SEL_W)) u_search (
        .clk       (clk),
        .rst       (rst),
        .start     (act.start_search),
        .wdata     (req_wdata),
        .user_mode (user_mode),
        .lk_req    (lk_req),
        .lk_vpn    (lk_vpn),
        .lk_user   (lk_user),
        .lk_ack    (lk_ack),
        .lk_hit    (lk_hit),
        .lk_index  (lk_index),
        .busy      (busy),
        .res_valid (res_valid),
        .res_hit   (res_hit),
        .res_index (res_index)
    );

    always_comb begin
        case (act.rsel)
            RSEL_DATA:  rd_next = req_ext ? data_out[63:32] : data_out[31:0];
            RSEL_TAG:   rd_next = tag_out;
            RSEL_ZONE:  rd_next = zone_q;
            RSEL_PROC:  rd_next = 32'(proc_q);
            RSEL_INDEX: rd_next = index_q;
            default:    rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            index_q    <= '0;
            proc_q     <= '0;
            zone_q     <= '0;
            rd_data_q  <= '0;
            rd_valid_q <= 1'b0;
            flush_q    <= 1'b0;
        end else begin
            rd_valid_q <= act.rd_en;
            rd_data_q  <= rd_next;
            flush_q    <= 1'b0;

            if (act.wr_index)
                index_q[30:0] <= req_wdata[30:0];
            else if (res_valid) begin
                if (res_hit) index_q <= 32'(res_index);
                else         index_q[31] <= 1'b1;
            end

            if (act.wr_proc) begin
                if (req_wdata[PROC_W-1:0] != proc_q) flush_q <= 1'b1;
                proc_q <= req_wdata[PROC_W-1:0];
            end else if (act.tag_read)
                proc_q <= owner_out;

            if (act.wr_zone) begin
                if (req_wdata != zone_q) flush_q <= 1'b1;
                zone_q <= req_wdata;
            end
        end
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;
    assign flush    = flush_q;
endmodule

// File: rtl/tlb_mgmt_regs_chk.sv
module tlb_mgmt_regs_chk
    import tlb_mgmt_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [1:0]  cfg_level,
    input logic [1:0]  cfg_access,
    input logic        req_valid,
    input logic        req_write,
    input logic [2:0]  req_reg,
    input logic        rd_valid,
    input logic [31:0] rd_data,
    input logic        flush,
    input logic        lk_req,
    input logic        lk_ack,
    input logic        lk_hit,
    input logic [31:0] index_q
);
    // R4
    miss_flag_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(index_q[31]) |-> $past(lk_req && lk_ack && !lk_hit));

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_req && !lk_ack) |=> lk_req);

    // R9
    closed_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(cfg_level < 2'd2 || cfg_access == 2'd0)) |-> (rd_data == 32'd0));

    // R11
    flush_source_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> $past(req_valid && req_write &&
                        (req_reg == REG_ZONE || req_reg == REG_PROC)));

    // R5
    search_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(lk_req) |-> $past(req_valid && req_write && req_reg == REG_SEARCH));

    // R6
    search_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && $past(req_valid && !req_write && req_reg == REG_SEARCH))
        |-> (rd_data == 32'd0));
endmodule

bind tlb_mgmt_regs tlb_mgmt_regs_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_level  (cfg_level),
    .cfg_access (cfg_access),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_reg    (req_reg),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .flush      (flush),
    .lk_req     (lk_req),
    .lk_ack     (lk_ack),
    .lk_hit     (lk_hit),
    .index_q    (index_q)
);

// File: tb/test_tlb_mgmt_regs.sv
module test_tlb_mgmt_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_level = 2'd2;
    logic [1:0]  cfg_access = 2'd3;
    logic        user_mode = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_ext = 1'b0;
    logic [2:0]  req_reg = 3'd0;
    logic [31:0] req_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        busy;
    logic        flush;
    logic        lk_req;
    logic [31:0] lk_vpn;
    logic        lk_user;
    logic        lk_ack = 1'b0;
    logic        lk_hit = 1'b0;
    logic [5:0]  lk_index = '0;

    int errors = 0;
    int checks = 0;
    logic last_flush;

    always #5 clk = ~clk;

    tlb_mgmt_regs i_tlb_mgmt_regs (
        .clk(clk), .rst(rst), .cfg_level(cfg_level), .cfg_access(cfg_access),
        .user_mode(user_mode), .req_valid(req_valid), .req_write(req_write),
        .req_ext(req_ext), .req_reg(req_reg), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .flush(flush),
        .lk_req(lk_req), .lk_vpn(lk_vpn), .lk_user(lk_user),
        .lk_ack(lk_ack), .lk_hit(lk_hit), .lk_index(lk_index)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] r, input logic [31:0] d, input logic ext = 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_reg = r; req_wdata = d; req_ext = ext;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; req_ext = 1'b0;
        last_flush = flush;
    endtask

    task automatic rd(input logic [2:0] r, output logic [31:0] d, input logic ext = 1'b0);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_reg = r; req_ext = ext;
        @(negedge clk);
        req_valid = 1'b0; req_ext = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 flush", {31'd0, flush}, 32'd0);
        rd(3'd4, v); check("R1 index", v, 32'd0);
        rd(3'd3, v); check("R1 proc", v, 32'd0);
        rd(3'd2, v); check("R1 zone", v, 32'd0);
        rd(3'd1, v); check("R1 tag", v, 32'd0);
        rd(3'd0, v); check("R1 data", v, 32'd0);
    endtask

    task automatic t_windows;
        logic [31:0] v;
        wr(3'd4, 32'h0000_0003);
        wr(3'd0, 32'hAAAA_0001);
        wr(3'd0, 32'hBBBB_0002, 1'b1);
        wr(3'd4, 32'h0000_0004);
        wr(3'd0, 32'hCCCC_0003);
        rd(3'd0, v); check("R2 entry4 data", v, 32'hCCCC_0003);
        wr(3'd4, 32'h0000_0043);
        rd(3'd0, v); check("R2 entry3 low", v, 32'hAAAA_0001);
        rd(3'd0, v, 1'b1); check("R10 entry3 upper", v, 32'hBBBB_0002);
        rd(3'd1, v, 1'b1); check("R10 ext tag read zero", v, 32'd0);
        wr(3'd1, 32'h1234_5678, 1'b1);
        rd(3'd1, v); check("R10 ext tag write ignored", v, 32'd0);
    endtask

    task automatic t_owner;
        logic [31:0] v;
        wr(3'd3, 32'h0000_005A);
        wr(3'd4, 32'h0000_0007);
        wr(3'd1, 32'hF000_0040);
        wr(3'd3, 32'h0000_0011);
        rd(3'd3, v); check("R3 proc before", v, 32'h11);
        rd(3'd1, v); check("R3 tag", v, 32'hF000_0040);
        rd(3'd3, v); check("R3 proc from owner", v, 32'h5A);
    endtask

    task automatic t_index;
        logic [31:0] v;
        wr(3'd4, 32'hFFFF_FF07);
        rd(3'd4, v); check("R4 bit31 not writable", v, 32'h7FFF_FF07);
        wr(3'd4, 32'h0000_0012);
    endtask

    task automatic search(input logic [31:0] val, input logic hit, input logic [5:0] idx,
                          input logic um, input logic [31:0] exp_vpn);
        logic [31:0] v;
        user_mode = um;
        wr(3'd5, val);
        check("R5 request", {31'd0, lk_req}, 32'd1);
        check("R5 vpn", lk_vpn, exp_vpn);
        check("R5 user", {31'd0, lk_user}, {31'd0, um});
        check("R12 busy", {31'd0, busy}, 32'd1);
        wr(3'd4, 32'h0000_003F);
        check("R12 held", {31'd0, lk_req}, 32'd1);
        @(negedge clk);
        lk_ack = 1'b1; lk_hit = hit; lk_index = idx;
        @(negedge clk);
        lk_ack = 1'b0; lk_hit = 1'b0;
        check("R12 released", {31'd0, lk_req}, 32'd0);
        v = 32'd0;
        rd(3'd4, v);
        v = v;
    endtask

    task automatic t_search;
        logic [31:0] v;
        search(32'h1234_57FF, 1'b0, 6'd0, 1'b1, 32'h1234_5400);
        rd(3'd4, v); check("R5 miss keeps bits, R12 write ignored", v, 32'h8000_0012);
        wr(3'd4, 32'h0000_0005);
        rd(3'd4, v); check("R4 miss flag survives write", v, 32'h8000_0005);
        search(32'h0000_0C01, 1'b1, 6'h2A, 1'b0, 32'h0000_0C00);
        rd(3'd4, v); check("R5 hit loads index", v, 32'h0000_002A);
        rd(3'd5, v); check("R6 search reads zero", v, 32'd0);
    endtask

    task automatic t_access;
        logic [31:0] v;
        cfg_access = 2'd1;
        wr(3'd3, 32'h0000_0077);
        wr(3'd2, 32'h0000_0077);
        wr(3'd5, 32'h0000_1000);
        check("R7 no search at level 1", {31'd0, lk_req}, 32'd0);
        rd(3'd3, v); check("R7 proc write ignored", v, 32'h5A);
        rd(3'd2, v); check("R7 zone write ignored", v, 32'd0);
        cfg_access = 2'd2;
        rd(3'd3, v); check("R8 proc read needs bit0", v, 32'd0);
        rd(3'd0, v); check("R8 data read needs bit0", v, 32'd0);
        rd(3'd4, v); check("R8 index read without bit0", v, 32'h0000_002A);
        cfg_access = 2'd3;
    endtask

    task automatic t_closed;
        logic [31:0] v;
        cfg_level = 2'd1;
        wr(3'd4, 32'h0000_0001);
        rd(3'd4, v); check("R9 low level read zero", v, 32'd0);
        cfg_level = 2'd2; cfg_access = 2'd0;
        wr(3'd4, 32'h0000_0002);
        rd(3'd4, v); check("R9 no access read zero", v, 32'd0);
        cfg_access = 2'd3;
        wr(3'd7, 32'h0000_0003);
        wr(3'd6, 32'h0000_0003);
        rd(3'd4, v); check("R9 writes ignored", v, 32'h0000_002A);
        rd(3'd7, v); check("R9 unknown read zero", v, 32'd0);
    endtask

    task automatic t_flush;
        wr(3'd2, 32'h0000_1234); check("R11 zone change", {31'd0, last_flush}, 32'd1);
        check("R11 one cycle", {31'd0, flush}, 32'd1);
        @(negedge clk); check("R11 pulse ends", {31'd0, flush}, 32'd0);
        wr(3'd2, 32'h0000_1234); check("R11 zone same", {31'd0, last_flush}, 32'd0);
        wr(3'd3, 32'h0000_005A); check("R11 proc same", {31'd0, last_flush}, 32'd0);
        wr(3'd3, 32'h0000_0099); check("R11 proc change", {31'd0, last_flush}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_windows();
        t_owner();
        t_index();
        t_search();
        t_access();
        t_closed();
        t_flush();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule